// File: doc/BRIEF.md
# Data Access Address Translation Checker

This block sits between a load/store unit and the physical memory side of a processor. It takes one data access request per cycle and returns either a physical address or a fault. The request carries a virtual address, an access size, a write flag, flags for physical-mode and alternate-mode access, and the lowest bit of the program counter. It also carries the current and alternate privilege modes. The result of a lookup in a separate translation buffer comes in on its own inputs: a hit flag, a physical page number, per-mode read and write enable masks, and fault-on-read and fault-on-write bits. The buffer storage itself is not part of this block.

The checks run in a fixed priority order: alignment, the physical-mode bypass, virtual address validity, the kernel-only superpage window, buffer miss, permissions, fault-on bits, and finally the implemented physical range and the uncached-region rules. When a check fails, the block reports a 3-bit fault code and a 6-bit status vector that says why. The result is registered, so it appears one clock after the request.

Top module: `dat_xlate_chk`

## Requirements
- R1: While `rst` is high, every output is zero on the next clock edge. Otherwise the outputs show the result for the inputs present at the previous rising edge. With no fault, `fault_o` is 0 and `status_o` is 0. Whenever `fault_o` is nonzero, `pa_o` and `uncached_o` are 0.
- R2: Alignment is checked first and wins over every other check. `size_i` gives the access size as log2 of its byte count (0 = 1 byte, up to 3 = 8 bytes). An alignment fault happens when `va_i & ((1<<size_i)-1)` is nonzero. It gives fault code 1, and its status holds only the write bit (status bit 0 = `wr_i`).
- R3: When `phys_i` is set, the physical address equals `va_i`. No validity, superpage, buffer or permission check applies in that case.
- R4: A virtual address is valid when bits 63:47 are all equal. An invalid address gives fault code 3 (page fault), with status bits write (0), access violation (1) and bad address (4).
- R5: Bits 47:41 equal to 7'h7E select the superpage window. The window is legal only when `cur_mode_i` is kernel (0); the override of R7 does not change this. Outside kernel mode the window gives fault code 2 (access violation) with status bits write (0) and access violation (1).
- R6: A superpage access maps to `va_i[43:0]`. If bit 40 of that value is set, bits 43:40 are forced to ones; otherwise bits 43:40 are cleared.
- R7: The effective mode for permission checks is `cur_mode_i` when `pc_lsb_i` is 0. When `pc_lsb_i` is 1, the effective mode is `alt_mode_i` if `alt_i` is set, and kernel (0) otherwise.
- R8: A miss (`tlb_hit_i` low) on a translated access gives fault code 4, or code 5 when `pte_fetch_i` is set. Its status holds write (0) and miss (5).
- R9: On a hit, the physical address is `{tlb_ppn_i, va_i[12:0]}`. The access is allowed when bit [effective mode] of `tlb_wr_en_i` (for writes) or `tlb_rd_en_i` (for reads) is set.
- R10: A failed permission check gives fault code 2. Its status holds access violation (1), write (0), and the fault-on bit for the access direction: bit 3 = `tlb_fon_wr_i` on writes, bit 2 = `tlb_fon_rd_i` on reads.
- R11: If permission passes but the fault-on bit for the access direction is set, the result is fault code 3. Its status holds only that fault-on bit plus the write bit.
- R12: A physical address with any of bits 63:44 set gives a machine check, fault code 6, with status 0.
- R13: A physical address with bit 43 set is uncached. If bits 43:20 are all ones, the address is in the unimplemented register space and the result is fault code 7. Otherwise `uncached_o` is 1 and bits 42:35 of `pa_o` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va_i | input | 64 | Virtual address of the access |
| size_i | input | 2 | Log2 of access size in bytes |
| wr_i | input | 1 | Access is a write |
| phys_i | input | 1 | Physical-mode access, bypass translation |
| alt_i | input | 1 | Use the alternate mode under privileged code |
| pte_fetch_i | input | 1 | Access is a page-table-entry fetch |
| pc_lsb_i | input | 1 | Bit 0 of the program counter (privileged code) |
| cur_mode_i | input | 2 | Current privilege mode, kernel = 0 |
| alt_mode_i | input | 2 | Alternate privilege mode |
| tlb_hit_i | input | 1 | Lookup hit |
| tlb_ppn_i | input | 31 | Physical page number from the lookup |
| tlb_rd_en_i | input | 4 | Read enable per mode |
| tlb_wr_en_i | input | 4 | Write enable per mode |
| tlb_fon_rd_i | input | 1 | Fault-on-read bit |
| tlb_fon_wr_i | input | 1 | Fault-on-write bit |
| pa_o | output | 64 | Physical address (0 on fault) |
| fault_o | output | 3 | Fault code |
| status_o | output | 6 | Status vector |
| uncached_o | output | 1 | Access goes to uncached space |

## Verification
Some properties hold on every cycle, and the assertions check those. A clean result has a clear status and no address bits above the implemented range. An alignment fault carries nothing but the write bit. A miss always carries the miss bit and never the access-violation bit. The bad-address bit appears only with a page fault. An uncached result always has bits 42:35 cleared. The bench scenarios cover what the assertions cannot. These are the priority between competing faults, the effective-mode override, the fact that superpage legality uses the raw current mode, the bit-40 sign extension, and the exact composed physical addresses.

// File: rtl/dat_pkg.sv
package dat_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_ACV   = 3'd2,
    FLT_PAGE  = 3'd3,
    FLT_MISS  = 3'd4,
    FLT_NMISS = 3'd5,
    FLT_MCHK  = 3'd6,
    FLT_UNIMP = 3'd7
  } fault_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_BADVA = 4;
  localparam int ST_MISS  = 5;

  localparam int         SPAGE_TAG_W = 7;
  localparam logic [6:0] SPAGE_TAG   = 7'h7E;
  localparam int         SEXT_BIT    = 40;
  localparam int         UNC_BIT     = 43;
  localparam int         UNC_CLR_HI  = 42;
  localparam int         UNC_CLR_LO  = 35;
  localparam int         REGSP_LO    = 20;
endpackage

// File: rtl/dat_mode_sel.sv
module dat_mode_sel #(
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  input  logic              pc_lsb,
  input  logic              alt_flag,
  output logic [MODE_W-1:0] eff_mode
);
  // privileged code may redirect the access to another mode
  always_comb begin
    if (!pc_lsb)       eff_mode = cur_mode;
    else if (alt_flag) eff_mode = alt_mode;
    else               eff_mode = '0;
  end
endmodule

// File: rtl/dat_va_class.sv
module dat_va_class
  import dat_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL_W = 48
) (
  input  logic [VA_W-1:0] va,
  output logic            va_ok,
  output logic            spage
);
  localparam int EXT_W = VA_W - VA_IMPL_W + 1;

  logic [EXT_W-1:0] ext;
  assign ext   = va[VA_W-1:VA_IMPL_W-1];
  assign va_ok = (&ext) | ~(|ext);
  assign spage = (va[VA_IMPL_W-1 -: SPAGE_TAG_W] == SPAGE_TAG);
endmodule

// File: rtl/dat_perm.sv
module dat_perm #(
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0]      eff_mode,
  input  logic                   wr,
  input  logic [(1<<MODE_W)-1:0] rd_en,
  input  logic [(1<<MODE_W)-1:0] wr_en,
  input  logic                   fon_rd,
  input  logic                   fon_wr,
  output logic                   perm_ok,
  output logic                   fon_hit
);
  localparam int NMODES = 1 << MODE_W;

  logic [NMODES-1:0] mode_oh;
  logic [NMODES-1:0] en_sel;

  assign mode_oh = NMODES'(1) << eff_mode;
  assign en_sel  = wr ? wr_en : rd_en;
  assign perm_ok = |(mode_oh & en_sel);
  assign fon_hit = wr ? fon_wr : fon_rd;
endmodule

// File: rtl/dat_pa_post.sv
module dat_pa_post
  import dat_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_IMPL_W = 44
) (
  input  logic [VA_W-1:0] pa_in,
  output logic            mchk,
  output logic            unc,
  output logic            regsp,
  output logic [VA_W-1:0] pa_out
);
  localparam int CLR_W = UNC_CLR_HI - UNC_CLR_LO + 1;

  assign mchk  = |pa_in[VA_W-1:PA_IMPL_W];
  assign unc   = pa_in[UNC_BIT];
  assign regsp = &pa_in[PA_IMPL_W-1:REGSP_LO];

  always_comb begin
    pa_out = pa_in;
    if (unc) pa_out[UNC_CLR_HI:UNC_CLR_LO] = {CLR_W{1'b0}};
  end
endmodule

// File: rtl/dat_xlate_chk.sv
module dat_xlate_chk
  import dat_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_IMPL_W  = 48,
  parameter int PA_IMPL_W  = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int MODE_W     = 2,
  parameter int SIZE_W     = 2,
  localparam int PPN_W     = PA_IMPL_W - PAGE_SHIFT,
  localparam int NMODES    = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   va_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              wr_i,
  input  logic              phys_i,
  input  logic              alt_i,
  input  logic              pte_fetch_i,
  input  logic              pc_lsb_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [MODE_W-1:0] alt_mode_i,
  input  logic              tlb_hit_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  input  logic [NMODES-1:0] tlb_rd_en_i,
  input  logic [NMODES-1:0] tlb_wr_en_i,
  input  logic              tlb_fon_rd_i,
  input  logic              tlb_fon_wr_i,
  output logic [VA_W-1:0]   pa_o,
  output logic [2:0]        fault_o,
  output logic [ST_W-1:0]   status_o,
  output logic              uncached_o
);
  localparam int AMASK_W = (1 << SIZE_W) + 1;
  localparam int HI_W    = VA_W - PA_IMPL_W;
  localparam int SEXT_W  = PA_IMPL_W - SEXT_BIT;

  logic [MODE_W-1:0] eff_mode;
  logic va_ok, spage, perm_ok, fon_hit;
  logic mchk, unc, regsp;
  logic [AMASK_W-1:0] amask;
  logic align_bad;
  logic [VA_W-1:0] sp_pa, hit_pa, pa_pre, pa_post;
  fault_e flt;
  logic [ST_W-1:0] st;

  dat_mode_sel #(.MODE_W(MODE_W)) u_mode (
    .cur_mode(cur_mode_i), .alt_mode(alt_mode_i), .pc_lsb(pc_lsb_i),
    .alt_flag(alt_i), .eff_mode(eff_mode)
  );

  dat_va_class #(.VA_W(VA_W), .VA_IMPL_W(VA_IMPL_W)) u_vacls (
    .va(va_i), .va_ok(va_ok), .spage(spage)
  );

  dat_perm #(.MODE_W(MODE_W)) u_perm (
    .eff_mode(eff_mode), .wr(wr_i), .rd_en(tlb_rd_en_i), .wr_en(tlb_wr_en_i),
    .fon_rd(tlb_fon_rd_i), .fon_wr(tlb_fon_wr_i),
    .perm_ok(perm_ok), .fon_hit(fon_hit)
  );

  dat_pa_post #(.VA_W(VA_W), .PA_IMPL_W(PA_IMPL_W)) u_post (
    .pa_in(pa_pre), .mchk(mchk), .unc(unc), .regsp(regsp), .pa_out(pa_post)
  );

  assign amask     = (AMASK_W'(1) << size_i) - AMASK_W'(1);
  assign align_bad = |(va_i[AMASK_W-1:0] & amask);

  assign sp_pa  = {{HI_W{1'b0}}, {SEXT_W{va_i[SEXT_BIT]}}, va_i[SEXT_BIT-1:0]};
  assign hit_pa = {{HI_W{1'b0}}, tlb_ppn_i, va_i[PAGE_SHIFT-1:0]};

  // fixed-priority fault selection
  always_comb begin
    flt    = FLT_NONE;
    st     = '0;
    pa_pre = va_i;
    if (align_bad) begin
      flt       = FLT_ALIGN;
      st[ST_WR] = wr_i;
    end else if (!phys_i) begin
      if (!va_ok) begin
        flt          = FLT_PAGE;
        st[ST_WR]    = wr_i;
        st[ST_ACV]   = 1'b1;
        st[ST_BADVA] = 1'b1;
      end else if (spage) begin
        pa_pre = sp_pa;
        if (cur_mode_i != '0) begin
          flt        = FLT_ACV;
          st[ST_WR]  = wr_i;
          st[ST_ACV] = 1'b1;
        end
      end else if (!tlb_hit_i) begin
        flt         = pte_fetch_i ? FLT_NMISS : FLT_MISS;
        st[ST_WR]   = wr_i;
        st[ST_MISS] = 1'b1;
      end else begin
        pa_pre = hit_pa;
        if (!perm_ok) begin
          flt         = FLT_ACV;
          st[ST_WR]   = wr_i;
          st[ST_ACV]  = 1'b1;
          st[ST_FONR] = !wr_i && tlb_fon_rd_i;
          st[ST_FONW] = wr_i && tlb_fon_wr_i;
        end else if (fon_hit) begin
          flt         = FLT_PAGE;
          st[ST_WR]   = wr_i;
          st[ST_FONR] = !wr_i;
          st[ST_FONW] = wr_i;
        end
      end
    end
    if (flt == FLT_NONE) begin
      if (mchk)              flt = FLT_MCHK;
      else if (unc && regsp) flt = FLT_UNIMP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_o       <= '0;
      fault_o    <= FLT_NONE;
      status_o   <= '0;
      uncached_o <= 1'b0;
    end else begin
      pa_o       <= (flt == FLT_NONE) ? pa_post : '0;
      fault_o    <= flt;
      status_o   <= st;
      uncached_o <= (flt == FLT_NONE) && unc;
    end
  end

  // R1 / R12: a clean result has no status and stays in the implemented range
  p_clean_ok_r12: assert property (@(posedge clk) disable iff (rst)
    (fault_o == FLT_NONE) |-> (status_o == '0 && pa_o[VA_W-1:PA_IMPL_W] == '0));

  // R2: alignment status carries only the write bit
  p_align_status_r2: assert property (@(posedge clk) disable iff (rst)
    (fault_o == FLT_ALIGN) |-> ((status_o & ~(ST_W'(1) << ST_WR)) == '0));

  // R8: a miss always reports the miss bit and never an access violation
  p_miss_status_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_o == FLT_MISS || fault_o == FLT_NMISS) |-> (status_o[ST_MISS] && !status_o[ST_ACV]));

  // R4: the bad-address bit only accompanies a page fault with violation
  p_badva_page_r4: assert property (@(posedge clk) disable iff (rst)
    status_o[ST_BADVA] |-> (fault_o == FLT_PAGE && status_o[ST_ACV]));

  // R13: uncached results are fault free with the cleared field
  p_uncached_r13: assert property (@(posedge clk) disable iff (rst)
    uncached_o |-> (fault_o == FLT_NONE && pa_o[UNC_BIT] &&
                    pa_o[UNC_CLR_HI:UNC_CLR_LO] == '0));
endmodule

// File: tb/dat_xlate_chk_bench.sv
module dat_xlate_chk_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] va_i = '0;
  logic [1:0]  size_i = '0;
  logic        wr_i = 1'b0, phys_i = 1'b0, alt_i = 1'b0, pte_fetch_i = 1'b0, pc_lsb_i = 1'b0;
  logic [1:0]  cur_mode_i = '0, alt_mode_i = '0;
  logic        tlb_hit_i = 1'b0;
  logic [30:0] tlb_ppn_i = '0;
  logic [3:0]  tlb_rd_en_i = '0, tlb_wr_en_i = '0;
  logic        tlb_fon_rd_i = 1'b0, tlb_fon_wr_i = 1'b0;
  logic [63:0] pa_o;
  logic [2:0]  fault_o;
  logic [5:0]  status_o;
  logic        uncached_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dat_xlate_chk u_dat_xlate_chk (
    .clk(clk), .rst(rst), .va_i(va_i), .size_i(size_i), .wr_i(wr_i),
    .phys_i(phys_i), .alt_i(alt_i), .pte_fetch_i(pte_fetch_i), .pc_lsb_i(pc_lsb_i),
    .cur_mode_i(cur_mode_i), .alt_mode_i(alt_mode_i), .tlb_hit_i(tlb_hit_i),
    .tlb_ppn_i(tlb_ppn_i), .tlb_rd_en_i(tlb_rd_en_i), .tlb_wr_en_i(tlb_wr_en_i),
    .tlb_fon_rd_i(tlb_fon_rd_i), .tlb_fon_wr_i(tlb_fon_wr_i),
    .pa_o(pa_o), .fault_o(fault_o), .status_o(status_o), .uncached_o(uncached_o)
  );

  typedef struct packed {
    logic [2:0]  f;
    logic [5:0]  st;
    logic [63:0] pa;
    logic        unc;
  } exp_t;

  function automatic exp_t ref_model();
    exp_t e;
    logic [1:0] em;
    logic [3:0] en;
    logic [63:0] pa;
    logic fon;
    e = '0;
    em = pc_lsb_i ? (alt_i ? alt_mode_i : 2'd0) : cur_mode_i;        // R7
    if ((va_i[3:0] & ((4'd1 << size_i) - 4'd1)) != 4'd0) begin       // R2
      e.f = 3'd1; e.st = {5'b0, wr_i}; return e;
    end
    pa = va_i;                                                      // R3
    if (!phys_i) begin
      if (!(&va_i[63:47] || ~|va_i[63:47])) begin                   // R4
        e.f = 3'd3; e.st = 6'b010010 | {5'b0, wr_i}; return e;
      end
      if (va_i[47:41] == 7'h7E) begin                               // R5, R6
        if (cur_mode_i != 2'd0) begin
          e.f = 3'd2; e.st = 6'b000010 | {5'b0, wr_i}; return e;
        end
        pa = {20'b0, va_i[40] ? 4'hF : 4'h0, va_i[39:0]};
      end else if (!tlb_hit_i) begin                                // R8
        e.f = pte_fetch_i ? 3'd5 : 3'd4; e.st = 6'b100000 | {5'b0, wr_i}; return e;
      end else begin                                                // R9
        pa = {20'b0, tlb_ppn_i, va_i[12:0]};
        en = wr_i ? tlb_wr_en_i : tlb_rd_en_i;
        fon = wr_i ? tlb_fon_wr_i : tlb_fon_rd_i;
        if (!en[em]) begin                                          // R10
          e.f = 3'd2;
          e.st = {2'b0, wr_i & fon, !wr_i & fon, 1'b1, wr_i};
          return e;
        end
        if (fon) begin                                              // R11
          e.f = 3'd3; e.st = {2'b0, wr_i, !wr_i, 1'b0, wr_i}; return e;
        end
      end
    end
    if (pa[63:44] != 20'b0) begin e.f = 3'd6; return e; end         // R12
    if (pa[43]) begin                                               // R13
      if (&pa[43:20]) begin e.f = 3'd7; return e; end
      pa[42:35] = 8'b0;
      e.unc = 1'b1;
    end
    e.pa = pa;
    return e;
  endfunction

  function automatic string tag_of(logic [2:0] f);
    case (f)
      3'd0: return "R9";
      3'd1: return "R2";
      3'd2: return "R10";
      3'd3: return "R11";
      3'd4, 3'd5: return "R8";
      3'd6: return "R12";
      default: return "R13";
    endcase
  endfunction

  // apply inputs (already set at a falling edge), sample one rising edge later
  task automatic run_check(input string tag);
    exp_t e;
    e = ref_model();
    @(negedge clk);
    checks++;
    if (fault_o !== e.f || status_o !== e.st || pa_o !== e.pa || uncached_o !== e.unc) begin
      failures++;
      $display("FAIL %s: got fault=%0d st=%b pa=%h unc=%b exp fault=%0d st=%b pa=%h unc=%b",
               tag, fault_o, status_o, pa_o, uncached_o, e.f, e.st, e.pa, e.unc);
    end
  endtask

  task automatic clear_inputs();
    va_i = '0; size_i = '0; wr_i = 0; phys_i = 0; alt_i = 0; pte_fetch_i = 0;
    pc_lsb_i = 0; cur_mode_i = 0; alt_mode_i = 0; tlb_hit_i = 1; tlb_ppn_i = 31'h1234;
    tlb_rd_en_i = 4'hF; tlb_wr_en_i = 4'hF; tlb_fon_rd_i = 0; tlb_fon_wr_i = 0;
  endtask

  task automatic randomize_inputs();
    logic [47:0] r;
    int region;
    r = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    region = int'($urandom % 4);
    phys_i = 1'b0;
    case (region)
      0: begin if (r[47:41] == 7'h7E) r[41] = ~r[41]; va_i = {{16{r[47]}}, r}; end
      1: begin r[47:41] = 7'h7E; va_i = {{16{r[47]}}, r}; end
      2: begin va_i = {{16{r[47]}}, r}; va_i[63] = ~r[47]; end
      default: begin
        phys_i = 1'b1;
        va_i = {$urandom, $urandom};
        if ($urandom % 2 == 0) va_i[63:44] = '0;
        if ($urandom % 4 == 0) va_i[43:20] = '1;
      end
    endcase
    size_i = 2'($urandom);
    if ($urandom % 4 != 0) va_i[2:0] = va_i[2:0] & ~(3'((4'd1 << size_i) - 4'd1));
    wr_i = 1'($urandom); alt_i = 1'($urandom); pte_fetch_i = 1'($urandom);
    pc_lsb_i = 1'($urandom); cur_mode_i = 2'($urandom); alt_mode_i = 2'($urandom);
    tlb_hit_i = ($urandom % 4 != 0); tlb_ppn_i = 31'($urandom);
    tlb_rd_en_i = 4'($urandom); tlb_wr_en_i = 4'($urandom);
    tlb_fon_rd_i = ($urandom % 4 == 0); tlb_fon_wr_i = ($urandom % 4 == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog R1: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset clears outputs even with an uncached physical request present
    clear_inputs();
    phys_i = 1; va_i = 64'h0000_0800_0000_1000;
    rst = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (pa_o !== '0 || fault_o !== '0 || status_o !== '0 || uncached_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: got pa=%h fault=%0d st=%b unc=%b exp all zero", pa_o, fault_o, status_o, uncached_o);
    end
    rst = 0;

    // R2: misaligned wins over physical mode and over a miss
    clear_inputs(); phys_i = 1; size_i = 2; va_i = 64'h2; wr_i = 1; run_check("R2");
    clear_inputs(); tlb_hit_i = 0; size_i = 3; va_i = 64'h4; run_check("R2");
    // R3: physical mode ignores a miss and a missing permission
    clear_inputs(); phys_i = 1; tlb_hit_i = 0; tlb_rd_en_i = 0; va_i = 64'h0000_0000_1234_5678; run_check("R3");
    // R4: invalid address
    clear_inputs(); va_i = 64'h0001_0000_0000_0000; wr_i = 1; run_check("R4");
    // R5: superpage in user mode, override to kernel does not help
    clear_inputs(); va_i = 64'hFFFF_FC00_0000_2000; cur_mode_i = 3; pc_lsb_i = 1; run_check("R5");
    // R6: superpage kernel, bit 40 clear and set
    clear_inputs(); va_i = 64'hFFFF_FC00_1234_5000; run_check("R6");
    clear_inputs(); va_i = 64'hFFFF_FD00_0012_3000; run_check("R6");
    // R7: override to kernel, and to alternate mode
    clear_inputs(); cur_mode_i = 3; pc_lsb_i = 1; tlb_rd_en_i = 4'b0001; va_i = 64'h4000; run_check("R7");
    clear_inputs(); cur_mode_i = 0; pc_lsb_i = 1; alt_i = 1; alt_mode_i = 2; tlb_rd_en_i = 4'b0001; va_i = 64'h4000; run_check("R7");
    // R8: miss, plain and page-table fetch
    clear_inputs(); tlb_hit_i = 0; wr_i = 1; va_i = 64'h8000; run_check("R8");
    clear_inputs(); tlb_hit_i = 0; pte_fetch_i = 1; va_i = 64'h8000; run_check("R8");
    // R9: hit with composed address
    clear_inputs(); cur_mode_i = 2; tlb_wr_en_i = 4'b0100; wr_i = 1; tlb_ppn_i = 31'h0ABC_DEF; va_i = 64'h1_FFF8; size_i = 3; run_check("R9");
    // R10: write denied with fault-on-write
    clear_inputs(); wr_i = 1; tlb_wr_en_i = 4'b1110; tlb_fon_wr_i = 1; tlb_fon_rd_i = 1; run_check("R10");
    // R11: read allowed but fault-on-read
    clear_inputs(); tlb_fon_rd_i = 1; tlb_fon_wr_i = 1; run_check("R11");
    // R12: physical address beyond range
    clear_inputs(); phys_i = 1; va_i = 64'h0000_1000_0000_0000; run_check("R12");
    // R13: uncached and register space
    clear_inputs(); tlb_ppn_i = 31'h4000_0000 | 31'h0FF0_0000; va_i = 64'h10; run_check("R13");
    clear_inputs(); phys_i = 1; va_i = 64'h0000_0FFF_FFF0_0040; run_check("R13");

    for (int i = 0; i < 3000; i++) begin
      exp_t e;
      randomize_inputs();
      e = ref_model();
      run_check(tag_of(e.f));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule